// File: doc/BRIEF.md
# Display Identification Block Reader

This controller runs on the source side of a display link. It reads the display identification data from a sink through a byte-level I2C command port. The bit-level bus master sits outside the block. The block issues one command at a time: start with an address byte, write a byte, read a byte, or stop. It waits for each command to complete before it issues the next.

When hot-plug detect rises, the controller waits a programmable settle time and then fetches block 0. For every block it first selects the segment, then writes the word offset, then reads 128 bytes. While block 0 arrives it checks the fixed eight-byte preamble and captures the extension count. That count sets how many further blocks to fetch, clipped to a parameterised capacity. Each received byte streams out at once, tagged with its block index and byte index. A per-block checksum flag records the result for each block. A done pulse closes a complete read. A fail pulse with a code closes an aborted read.

The states are IDLE, SETTLE, SEG_ADR, SEG_DAT, SEG_STP, OFF_ADR, OFF_DAT, RD_ADR, RD_DAT, RD_STP, NEXT, DONE, ABT_STP, FAIL and HOLD. The transitions are:
- IDLE goes to SETTLE when hot-plug detect is high.
- SETTLE goes to SEG_ADR when the timer expires.
- SEG_ADR goes to SEG_DAT on an ACK. On a NACK it goes to SEG_STP when the block index is 1 or less, and to ABT_STP otherwise.
- SEG_DAT goes to SEG_STP, then SEG_STP goes to OFF_ADR.
- OFF_ADR goes to OFF_DAT on an ACK and to ABT_STP on a NACK.
- OFF_DAT goes to RD_ADR.
- RD_ADR goes to RD_DAT on an ACK and to ABT_STP on a NACK.
- RD_DAT goes to RD_STP after the 128th byte, then RD_STP goes to NEXT.
- NEXT goes back to SEG_ADR when more blocks remain, and to DONE otherwise.
- DONE goes to HOLD, and ABT_STP goes to FAIL and then to HOLD.
- Any state goes to IDLE when hot-plug detect is low.

Top module: `edid_seq`

## Requirements
- R1: While hot-plug detect is low, no command is issued. After it rises, no command is issued for at least SETTLE_CYCLES clock cycles.
- R2: Each block B is fetched with this command sequence, and the segment write is made even for B = 0:
  - start with address byte 0x60, write the byte floor(B/2), stop;
  - start with address byte 0xA0, write the offset byte (0x00 when B is even, 0x80 when B is odd);
  - start with address byte 0xA1, read 128 bytes with op_last set only on the 128th, stop.
  The op_code encoding is 0 = start, 1 = write, 2 = read, 3 = stop.
- R3: header_ok is 1 when bytes 0 to 7 of block 0 are 00 FF FF FF FF FF FF 00, and 0 otherwise.
- R4: blk_ok bit B is 1 when the modulo-256 sum of the 128 bytes of block B is zero.
- R5: The number of blocks read is (byte 126 of block 0) + 1, clipped to MAX_BLOCKS. blk_count reports that number at done.
- R6: Every byte read produces one byte_valid cycle carrying the data, the block index and the byte index 0 to 127, in read order.
- R7: A NACK on address byte 0xA0 or 0xA1 causes a stop, a one-cycle fail with fail_code 1, and no done.
- R8: A NACK on address byte 0x60 is tolerated for block indices 0 and 1, and the offset write follows. For block index 2 or above it causes a stop and a fail with fail_code 2.
- R9: done pulses for one cycle after the last block. header_ok, blk_ok and blk_count then hold until hot-plug detect falls.
- R10: One cycle after hot-plug detect is seen low, op_valid is low and blk_ok, header_ok and blk_count are zero.
- R11: op_code and op_byte stay stable while op_valid is high and op_done has not arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hpd | input | 1 | Hot-plug detect from the sink |
| op_valid | output | 1 | A bus command is pending |
| op_code | output | 2 | 0 start, 1 write, 2 read, 3 stop |
| op_byte | output | 8 | Address byte for start, data byte for write |
| op_last | output | 1 | Read byte is to be answered with NACK |
| op_done | input | 1 | One-cycle completion of the pending command |
| op_ack | input | 1 | Address or write was acknowledged, valid with op_done |
| op_rdata | input | 8 | Byte read, valid with op_done |
| byte_valid | output | 1 | Streamed byte strobe |
| byte_data | output | 8 | Streamed byte |
| byte_blk | output | IDX_W | Block index of the streamed byte |
| byte_idx | output | 7 | Byte index within the block |
| done | output | 1 | Complete read finished |
| header_ok | output | 1 | Block 0 preamble matched |
| blk_ok | output | MAX_BLOCKS | Per-block checksum result |
| blk_count | output | CNT_W | Number of blocks read |
| fail | output | 1 | Read aborted |
| fail_code | output | 2 | 1 no sink, 2 segment pointer missing |

## Verification
The checker assumes three things about the inputs. op_done is a single-cycle pulse that arrives only while op_valid is high. op_ack and op_rdata are meaningful only in that cycle. hpd holds a known level from reset onwards. The bench's command-level bus model keeps to these rules. It samples one pending command, answers it after a fixed latency with one op_done pulse, and drops any command that op_valid withdraws because hot-plug detect fell. The model's segment register starts at a nonzero value and is never cleared by a stop. A missing segment write therefore shows up as wrong streamed data.

// File: rtl/edid_seq_pkg.sv
package edid_seq_pkg;

    typedef enum logic [1:0] {
        OP_START = 2'd0,
        OP_WRITE = 2'd1,
        OP_READ  = 2'd2,
        OP_STOP  = 2'd3
    } op_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_SETTLE,
        S_SEG_ADR,
        S_SEG_DAT,
        S_SEG_STP,
        S_OFF_ADR,
        S_OFF_DAT,
        S_RD_ADR,
        S_RD_DAT,
        S_RD_STP,
        S_NEXT,
        S_DONE,
        S_ABT_STP,
        S_FAIL,
        S_HOLD
    } st_e;

    localparam logic [6:0] SEG_DEV   = 7'h30;
    localparam logic [6:0] ROM_DEV   = 7'h50;
    localparam int         BLK_BYTES = 128;

    localparam logic [1:0] FAIL_NONE   = 2'd0;
    localparam logic [1:0] FAIL_NOSINK = 2'd1;
    localparam logic [1:0] FAIL_NOSEG  = 2'd2;

endpackage

// File: rtl/edid_settle_timer.sv
module edid_settle_timer #(
    parameter int CYCLES = 500000,
    localparam int CW = $clog2(CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run) begin
            cnt <= '0;
        end else if (!expired) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expired = run && (cnt == CW'(CYCLES - 1));

endmodule

// File: rtl/edid_blk_acc.sv
module edid_blk_acc (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       hdr_clr,
    input  logic       en,
    input  logic [6:0] idx,
    input  logic [7:0] data,
    output logic       sum_zero,
    output logic       hdr_ok,
    output logic [7:0] ext_cnt
);

    logic [7:0] sum;
    logic       hdr_bad;
    logic [7:0] hdr_exp;

    assign hdr_exp = (idx == 7'd0 || idx == 7'd7) ? 8'h00 : 8'hFF;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sum     <= '0;
            hdr_bad <= 1'b0;
            ext_cnt <= '0;
        end else begin
            if (clr) begin
                sum <= '0;
            end else if (en) begin
                sum <= sum + data;
            end
            if (hdr_clr) begin
                hdr_bad <= 1'b0;
            end else if (en && idx < 7'd8 && data != hdr_exp) begin
                hdr_bad <= 1'b1;
            end
            if (en && idx == 7'd126) begin
                ext_cnt <= data;
            end
        end
    end

    assign sum_zero = (sum == 8'h00);
    assign hdr_ok   = !hdr_bad;

endmodule

// File: rtl/edid_seq.sv
module edid_seq
    import edid_seq_pkg::*;
#(
    parameter int MAX_BLOCKS    = 8,
    parameter int SETTLE_CYCLES = 500000,
    localparam int IDX_W = (MAX_BLOCKS > 1) ? $clog2(MAX_BLOCKS) : 1,
    localparam int CNT_W = $clog2(MAX_BLOCKS + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  hpd,
    output logic                  op_valid,
    output logic [1:0]            op_code,
    output logic [7:0]            op_byte,
    output logic                  op_last,
    input  logic                  op_done,
    input  logic                  op_ack,
    input  logic [7:0]            op_rdata,
    output logic                  byte_valid,
    output logic [7:0]            byte_data,
    output logic [IDX_W-1:0]      byte_blk,
    output logic [6:0]            byte_idx,
    output logic                  done,
    output logic                  header_ok,
    output logic [MAX_BLOCKS-1:0] blk_ok,
    output logic [CNT_W-1:0]      blk_count,
    output logic                  fail,
    output logic [1:0]            fail_code
);

    st_e              st, st_nx;
    logic [IDX_W-1:0] blk;
    logic [6:0]       bcnt;
    logic [CNT_W-1:0] total;
    logic [1:0]       fcode_r;

    logic             settle_done;
    logic             rd_strobe;
    logic             sum_zero;
    logic             acc_hdr;
    logic [7:0]       ext_cnt;

    logic [8:0]       need;
    logic [CNT_W-1:0] eff_total;
    logic [CNT_W-1:0] cur_total;
    logic [CNT_W-1:0] blk_inc;
    logic             last_blk;
    logic [7:0]       seg_byte;

    edid_settle_timer #(.CYCLES(SETTLE_CYCLES)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (st == S_SETTLE),
        .expired (settle_done)
    );

    edid_blk_acc u_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (st == S_RD_ADR),
        .hdr_clr  (st == S_RD_ADR && blk == '0),
        .en       (rd_strobe),
        .idx      (bcnt),
        .data     (op_rdata),
        .sum_zero (sum_zero),
        .hdr_ok   (acc_hdr),
        .ext_cnt  (ext_cnt)
    );

    assign rd_strobe = (st == S_RD_DAT) && op_done;

    // Block budget: extension count plus base block, clipped to capacity
    always_comb begin
        need      = {1'b0, ext_cnt} + 9'd1;
        eff_total = (need > 9'(MAX_BLOCKS)) ? CNT_W'(MAX_BLOCKS) : CNT_W'(need);
        cur_total = (blk == '0) ? eff_total : total;
        blk_inc   = CNT_W'(blk) + 1'b1;
        last_blk  = (blk_inc >= cur_total);
        seg_byte  = 8'(blk >> 1);
    end

    // Next-state logic
    always_comb begin
        st_nx = st;
        unique case (st)
            S_IDLE:    if (hpd) st_nx = S_SETTLE;
            S_SETTLE:  if (settle_done) st_nx = S_SEG_ADR;
            S_SEG_ADR: if (op_done) begin
                           if (op_ack)                         st_nx = S_SEG_DAT;
                           else if (blk <= IDX_W'(1))          st_nx = S_SEG_STP;
                           else                                st_nx = S_ABT_STP;
                       end
            S_SEG_DAT: if (op_done) st_nx = S_SEG_STP;
            S_SEG_STP: if (op_done) st_nx = S_OFF_ADR;
            S_OFF_ADR: if (op_done) st_nx = op_ack ? S_OFF_DAT : S_ABT_STP;
            S_OFF_DAT: if (op_done) st_nx = S_RD_ADR;
            S_RD_ADR:  if (op_done) st_nx = op_ack ? S_RD_DAT : S_ABT_STP;
            S_RD_DAT:  if (op_done && bcnt == 7'(BLK_BYTES - 1)) st_nx = S_RD_STP;
            S_RD_STP:  if (op_done) st_nx = S_NEXT;
            S_NEXT:    st_nx = last_blk ? S_DONE : S_SEG_ADR;
            S_DONE:    st_nx = S_HOLD;
            S_ABT_STP: if (op_done) st_nx = S_FAIL;
            S_FAIL:    st_nx = S_HOLD;
            S_HOLD:    st_nx = S_HOLD;
            default:   st_nx = S_IDLE;
        endcase
        if (!hpd) st_nx = S_IDLE;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= st_nx;
    end

    // Sequencing counters and results
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            blk       <= '0;
            bcnt      <= '0;
            total     <= '0;
            blk_ok    <= '0;
            header_ok <= 1'b0;
            blk_count <= '0;
            fcode_r   <= FAIL_NONE;
        end else if (!hpd) begin
            blk       <= '0;
            bcnt      <= '0;
            total     <= '0;
            blk_ok    <= '0;
            header_ok <= 1'b0;
            blk_count <= '0;
            fcode_r   <= FAIL_NONE;
        end else begin
            if (st == S_SETTLE) begin
                blk  <= '0;
                bcnt <= '0;
            end
            if (st == S_RD_ADR) bcnt <= '0;
            if (rd_strobe)      bcnt <= bcnt + 1'b1;
            if (st == S_SEG_ADR && op_done && !op_ack && blk > IDX_W'(1))
                fcode_r <= FAIL_NOSEG;
            if ((st == S_OFF_ADR || st == S_RD_ADR) && op_done && !op_ack)
                fcode_r <= FAIL_NOSINK;
            if (st == S_NEXT) begin
                blk_ok[blk] <= sum_zero;
                blk_count   <= blk_inc;
                if (blk == '0) begin
                    header_ok <= acc_hdr;
                    total     <= eff_total;
                end
                if (!last_blk) blk <= blk + 1'b1;
            end
        end
    end

    // Outputs
    always_comb begin
        op_valid   = 1'b0;
        op_code    = OP_STOP;
        op_byte    = 8'h00;
        op_last    = 1'b0;
        unique case (st)
            S_SEG_ADR: begin op_valid = 1'b1; op_code = OP_START; op_byte = {SEG_DEV, 1'b0}; end
            S_SEG_DAT: begin op_valid = 1'b1; op_code = OP_WRITE; op_byte = seg_byte; end
            S_SEG_STP: begin op_valid = 1'b1; op_code = OP_STOP; end
            S_OFF_ADR: begin op_valid = 1'b1; op_code = OP_START; op_byte = {ROM_DEV, 1'b0}; end
            S_OFF_DAT: begin op_valid = 1'b1; op_code = OP_WRITE; op_byte = {blk[0], 7'b0}; end
            S_RD_ADR:  begin op_valid = 1'b1; op_code = OP_START; op_byte = {ROM_DEV, 1'b1}; end
            S_RD_DAT:  begin
                           op_valid = 1'b1;
                           op_code  = OP_READ;
                           op_last  = (bcnt == 7'(BLK_BYTES - 1));
                       end
            S_RD_STP,
            S_ABT_STP: begin op_valid = 1'b1; op_code = OP_STOP; end
            default:   begin end
        endcase
        byte_valid = rd_strobe;
        byte_data  = op_rdata;
        byte_blk   = blk;
        byte_idx   = bcnt;
        done       = (st == S_DONE);
        fail       = (st == S_FAIL);
        fail_code  = fcode_r;
    end

endmodule

// File: rtl/edid_seq_chk.sv
module edid_seq_chk #(
    parameter int MAX_BLOCKS = 8,
    parameter int CNT_W      = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  hpd,
    input logic                  op_valid,
    input logic [1:0]            op_code,
    input logic [7:0]            op_byte,
    input logic                  op_last,
    input logic                  op_done,
    input logic                  byte_valid,
    input logic                  done,
    input logic                  fail,
    input logic [MAX_BLOCKS-1:0] blk_ok,
    input logic [CNT_W-1:0]      blk_count
);

    // R11: command held until completion
    a_r11_op_hold: assert property (@(posedge clk) disable iff (!rst_n || !hpd)
        (op_valid && !op_done) |=> (op_valid && $stable(op_code) && $stable(op_byte)));

    // R10: hot-plug loss idles and clears
    a_r10_hpd_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !hpd |=> (!op_valid && blk_ok == '0 && blk_count == '0 && !done));

    // R7: abort and completion never coincide
    a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && fail));

    // R9: done is a single-cycle pulse
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R5: reported count within capacity
    a_r5_count_range: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (blk_count >= CNT_W'(1) && blk_count <= CNT_W'(MAX_BLOCKS)));

    // R2: NACK marker only on reads
    a_r2_last_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        op_last |-> (op_valid && op_code == 2'd2));

    // R6: streamed bytes come from completed reads
    a_r6_byte_from_read: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |-> (op_valid && op_done && op_code == 2'd2));

endmodule

bind edid_seq edid_seq_chk #(.MAX_BLOCKS(MAX_BLOCKS), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .hpd        (hpd),
    .op_valid   (op_valid),
    .op_code    (op_code),
    .op_byte    (op_byte),
    .op_last    (op_last),
    .op_done    (op_done),
    .byte_valid (byte_valid),
    .done       (done),
    .fail       (fail),
    .blk_ok     (blk_ok),
    .blk_count  (blk_count)
);

// File: tb/test_edid_seq.sv
module test_edid_seq;

    localparam int SETTLE = 100;
    localparam int MAXB   = 8;
    localparam int IDXW   = 3;
    localparam int CNTW   = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            hpd = 1'b0;
    logic            op_valid;
    logic [1:0]      op_code;
    logic [7:0]      op_byte;
    logic            op_last;
    logic            op_done = 1'b0;
    logic            op_ack = 1'b0;
    logic [7:0]      op_rdata = 8'h00;
    logic            byte_valid;
    logic [7:0]      byte_data;
    logic [IDXW-1:0] byte_blk;
    logic [6:0]      byte_idx;
    logic            done;
    logic            header_ok;
    logic [MAXB-1:0] blk_ok;
    logic [CNTW-1:0] blk_count;
    logic            fail;
    logic [1:0]      fail_code;

    always #2 clk = ~clk;

    edid_seq #(.MAX_BLOCKS(MAXB), .SETTLE_CYCLES(SETTLE)) i_edid_seq (
        .clk(clk), .rst_n(rst_n), .hpd(hpd),
        .op_valid(op_valid), .op_code(op_code), .op_byte(op_byte), .op_last(op_last),
        .op_done(op_done), .op_ack(op_ack), .op_rdata(op_rdata),
        .byte_valid(byte_valid), .byte_data(byte_data), .byte_blk(byte_blk), .byte_idx(byte_idx),
        .done(done), .header_ok(header_ok), .blk_ok(blk_ok), .blk_count(blk_count),
        .fail(fail), .fail_code(fail_code)
    );

    typedef struct {
        int         blk;
        int         idx;
        logic [7:0] data;
    } exp_t;

    exp_t       expq[$];
    int         seg_log[$];
    int         off_log[$];
    logic [7:0] mem [0:2047];
    bit         seg_present = 1'b1;
    bit         sink_present = 1'b1;
    logic [7:0] mdl_seg = 8'h05;
    logic [7:0] mdl_ptr = 8'h00;
    logic [7:0] mdl_dev = 8'h00;

    int checks = 0;
    int fails  = 0;
    int done_cnt = 0;
    int fail_cnt = 0;
    logic            cap_hdr;
    logic [MAXB-1:0] cap_ok;
    logic [CNTW-1:0] cap_cnt;
    logic [1:0]      cap_code;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Command-level bus model
    initial begin
        logic [1:0] c;
        logic [7:0] b;
        int         a;
        forever begin
            @(negedge clk);
            if (op_valid) begin
                c = op_code;
                b = op_byte;
                repeat (2) @(negedge clk);
                if (!op_valid) continue;
                op_ack = 1'b1;
                case (c)
                    2'd0: begin
                        mdl_dev = b;
                        op_ack = (b == 8'h60) ? seg_present :
                                 (b == 8'hA0 || b == 8'hA1) ? sink_present : 1'b0;
                        if (b == 8'hA1 && sink_present) begin
                            seg_log.push_back(seg_present ? int'(mdl_seg) : 0);
                            off_log.push_back(int'(mdl_ptr));
                        end
                    end
                    2'd1: begin
                        if (mdl_dev == 8'h60) mdl_seg = b;
                        else if (mdl_dev == 8'hA0) mdl_ptr = b;
                    end
                    2'd2: begin
                        a = ((seg_present ? int'(mdl_seg) : 0) * 256 + int'(mdl_ptr)) % 2048;
                        op_rdata = mem[a];
                        mdl_ptr = mdl_ptr + 8'd1;
                    end
                    default: ;
                endcase
                op_done = 1'b1;
                @(negedge clk);
                op_done = 1'b0;
            end
        end
    end

    // Scoreboard monitor
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            #1;
            if (byte_valid) begin
                if (expq.size() == 0) begin
                    chk(1'b0, "R6", "unexpected byte", int'(byte_data), 0);
                end else begin
                    e = expq.pop_front();
                    chk(byte_blk == IDXW'(e.blk) && byte_idx == 7'(e.idx) && byte_data == e.data,
                        "R6", $sformatf("byte blk%0d idx%0d", e.blk, e.idx),
                        {byte_blk, byte_idx, byte_data}, {IDXW'(e.blk), 7'(e.idx), e.data});
                end
            end
            if (done) begin
                done_cnt++;
                cap_hdr = header_ok;
                cap_ok  = blk_ok;
                cap_cnt = blk_count;
            end
            if (fail) begin
                fail_cnt++;
                cap_code = fail_code;
            end
        end
    end

    task automatic build_image(input int ext, input int bad_blk, input bit bad_hdr);
        int s;
        for (int i = 0; i < 2048; i++) mem[i] = 8'h5A;
        for (int b = 0; b < MAXB; b++) begin
            for (int i = 0; i < 127; i++) mem[b*128 + i] = 8'((b*37 + i*7 + 3) & 255);
            if (b == 0) begin
                mem[0] = 8'h00;
                for (int i = 1; i < 7; i++) mem[i] = 8'hFF;
                mem[7] = 8'h00;
                if (bad_hdr) mem[3] = 8'hFE;
                mem[126] = 8'(ext);
            end
            s = 0;
            for (int i = 0; i < 127; i++) s += int'(mem[b*128 + i]);
            mem[b*128 + 127] = 8'((256 - (s % 256)) % 256);
            if (b == bad_blk) mem[b*128 + 127] = mem[b*128 + 127] ^ 8'h01;
        end
    endtask

    task automatic push_expect(input int nblk);
        for (int b = 0; b < nblk; b++)
            for (int i = 0; i < 128; i++)
                expq.push_back('{b, i, mem[b*128 + i]});
    endtask

    task automatic restart();
        hpd = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        chk(!op_valid && blk_ok == '0 && blk_count == '0 && !header_ok, "R10",
            "cleared after hpd low", int'(blk_ok), 0);
        expq.delete();
        seg_log.delete();
        off_log.delete();
        mdl_seg = 8'h05;
        @(negedge clk);
        hpd = 1'b1;
    endtask

    task automatic wait_end(output bit got_done, output bit got_fail);
        int d0 = done_cnt;
        int f0 = fail_cnt;
        got_done = 1'b0;
        got_fail = 1'b0;
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            #2;
            if (done_cnt != d0 || fail_cnt != f0) break;
        end
        got_done = (done_cnt != d0);
        got_fail = (fail_cnt != f0);
        repeat (4) @(negedge clk);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=0 expected=1");
        summary();
        $finish;
    end

    initial begin
        bit gd, gf;
        int wait_cyc;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (20) @(negedge clk);
        #1;
        chk(!op_valid && !done && !fail && blk_ok == '0, "R1", "idle with hpd low", int'(op_valid), 0);

        // A: three extensions, all good, settle timing, segment/offset log
        build_image(3, -1, 1'b0);
        push_expect(4);
        mdl_seg = 8'h05;
        @(negedge clk);
        hpd = 1'b1;
        wait_cyc = 0;
        for (int i = 0; i < 1000; i++) begin
            @(negedge clk);
            if (op_valid) break;
            wait_cyc++;
        end
        chk(wait_cyc >= SETTLE, "R1", "settle cycles before first command", wait_cyc, SETTLE);
        chk(op_code == 2'd0 && op_byte == 8'h60, "R2", "first command is segment start",
            int'(op_byte), 'h60);
        wait_end(gd, gf);
        chk(gd && !gf, "R9", "done after full read", int'(gd), 1);
        chk(cap_hdr == 1'b1, "R3", "header ok", int'(cap_hdr), 1);
        chk(cap_ok == 8'h0F, "R4", "checksum flags", int'(cap_ok), 'h0F);
        chk(cap_cnt == 4'd4, "R5", "block count", int'(cap_cnt), 4);
        chk(seg_log.size() == 4 && seg_log[0] == 0 && seg_log[1] == 0 && seg_log[2] == 1 && seg_log[3] == 1,
            "R2", "segments per block", seg_log.size(), 4);
        chk(off_log.size() == 4 && off_log[0] == 0 && off_log[1] == 'h80 && off_log[2] == 0 && off_log[3] == 'h80,
            "R2", "offsets per block", off_log.size(), 4);
        chk(expq.size() == 0, "R6", "all bytes streamed", expq.size(), 0);
        chk(blk_ok == 8'h0F && blk_count == 4'd4 && header_ok, "R9", "results held", int'(blk_ok), 'h0F);

        // B: extension count beyond capacity, block 5 corrupted
        build_image(10, 5, 1'b0);
        restart();
        push_expect(MAXB);
        wait_end(gd, gf);
        chk(gd, "R5", "done with clipped read", int'(gd), 1);
        chk(cap_cnt == 4'(MAXB), "R5", "clipped block count", int'(cap_cnt), MAXB);
        chk(cap_ok == 8'hDF, "R4", "bad block flagged", int'(cap_ok), 'hDF);
        chk(seg_log.size() == MAXB && seg_log[MAXB-1] == 3 && off_log[MAXB-1] == 'h80,
            "R2", "last block segment/offset", seg_log.size(), MAXB);
        chk(expq.size() == 0, "R6", "all clipped bytes streamed", expq.size(), 0);

        // C: no segment device, one extension, bad header
        seg_present = 1'b0;
        build_image(1, -1, 1'b1);
        restart();
        push_expect(2);
        wait_end(gd, gf);
        chk(gd && !gf, "R8", "segment NACK tolerated for blocks 0-1", int'(gd), 1);
        chk(cap_hdr == 1'b0, "R3", "bad header detected", int'(cap_hdr), 0);
        chk(cap_ok == 8'h03 && cap_cnt == 4'd2, "R4", "flags with tolerated segment", int'(cap_ok), 3);

        // D: no segment device, block 2 needed
        build_image(3, -1, 1'b0);
        restart();
        push_expect(2);
        wait_end(gd, gf);
        chk(gf && !gd, "R8", "fail at block 2", int'(gf), 1);
        chk(cap_code == 2'd2, "R8", "fail code segment", int'(cap_code), 2);
        chk(expq.size() == 0, "R8", "blocks 0-1 streamed before abort", expq.size(), 0);
        seg_present = 1'b1;

        // E: no sink
        sink_present = 1'b0;
        build_image(0, -1, 1'b0);
        restart();
        wait_end(gd, gf);
        chk(gf && !gd, "R7", "fail without done", int'(gd), 0);
        chk(cap_code == 2'd1, "R7", "fail code no sink", int'(cap_code), 1);
        sink_present = 1'b1;

        // F: hpd drop mid-read, then a clean base-only read
        build_image(3, -1, 1'b0);
        restart();
        push_expect(4);
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (expq.size() < 300) break;
        end
        hpd = 1'b0;
        repeat (2) @(negedge clk);
        #1;
        chk(!op_valid && blk_ok == '0 && done_cnt >= 0, "R10", "idle after mid-read drop", int'(op_valid), 0);
        build_image(0, -1, 1'b0);
        restart();
        push_expect(1);
        wait_end(gd, gf);
        chk(gd && cap_cnt == 4'd1 && cap_ok == 8'h01, "R5", "base-only read", int'(cap_cnt), 1);
        chk(seg_log.size() == 1 && seg_log[0] == 0, "R2", "segment 0 written for base", seg_log.size(), 1);

        summary();
        $finish;
    end

endmodule